// File: doc/BRIEF.md
# Tile Shape Configuration Register

This block keeps the shape settings for a bank of two-dimensional tile registers. Software writes a 64-byte configuration image one byte at a time into a staging buffer. Writing the final byte, at address 63, starts a commit. The block then decides whether the staged image is legal. A legal image with palette 1 becomes the live configuration. The live per-tile row counts and bytes-per-row values, together with a configured flag, are driven to the tile datapath.

An image whose palette byte is zero does not configure anything. It returns the block to its init state and sends a one-cycle request to clear all tile data. A release command does the same. An illegal image raises a one-cycle fault pulse and leaves the live configuration as it was.

A read port returns any byte of the live image one cycle after it is requested. While nothing is configured, every byte reads back as zero.

Top module: `tile_cfg_reg`

## Requirements
- R1: After reset, `cfg_ok`, `fault`, `tile_clr`, `tile_rows` and `tile_bpr` are all zero.
- R2: Image layout:
  - byte 0 is the palette;
  - the bytes-per-row of tile t is a little-endian 16-bit field at bytes 16+2t and 17+2t;
  - the row count of tile t is byte 48+t.

  When the byte at address 63 is accepted on a clock edge, the next edge applies a legal palette-1 image. After that edge `cfg_ok` is 1, and tile t appears in `tile_rows[5t+4:5t]` and `tile_bpr[7t+6:7t]`.
- R3: A committed image whose palette byte is 0 clears `cfg_ok` and every shape. It pulses `tile_clr` for exactly one cycle and raises no fault, whatever the other bytes hold.
- R4: A committed image with a palette above 1 pulses `fault` for one cycle and leaves `cfg_ok` and every shape unchanged.
- R5: A row count above 16 for any of the 8 used tiles is a fault.
- R6: A bytes-per-row value above 64, or one that is not a multiple of 4, for any used tile is a fault.
- R7: A nonzero reserved byte is a fault. The reserved bytes are:
  - bytes 1 to 15;
  - the bytes-per-row fields of tiles 8 to 15 (bytes 32 to 47);
  - the row counts of tiles 8 to 15 (bytes 56 to 63).
- R8: A read of address a with `rd_en` shows the live image byte at `rd_data` one cycle later. Reserved bytes read as zero.
- R9: While `cfg_ok` is 0, every read returns zero.
- R10: `release_i` clears `cfg_ok` and every shape on the next edge and pulses `tile_clr` for one cycle.
- R11: If a release and a commit fall on the same edge, the release wins. The staged image is dropped and no fault is raised.
- R12: The limit values are legal and are applied: 16 rows, 64 bytes per row, and zero rows or zero bytes per row.
- R13: Writes to addresses other than 63 change only the staging buffer. The outputs stay the same until byte 63 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Staging byte write strobe |
| wr_addr | input | 6 | Staging byte address; 63 triggers a commit |
| wr_data | input | 8 | Staging byte value |
| rd_en | input | 1 | Readback request |
| rd_addr | input | 6 | Readback byte address |
| rd_data | output | 8 | Readback byte, one cycle after request |
| release_i | input | 1 | Return to init state |
| cfg_ok | output | 1 | A valid configuration is held |
| fault | output | 1 | One-cycle pulse on an illegal commit |
| tile_clr | output | 1 | One-cycle request to zero all tile data |
| tile_rows | output | 40 | Row count per tile, 5 bits each |
| tile_bpr | output | 56 | Bytes per row per tile, 7 bits each |

## Verification
A release and the commit of a staged image can land on the same clock edge. That case decides whether a configuration survives a release. The bench stages a full legal image, writes byte 63, and raises `release_i` in the very next cycle, which is the cycle in which the commit is evaluated. It then expects the init state, a `tile_clr` pulse and no fault. A later readback of zeros confirms that the dropped image did not leak into the live state.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int IMG_BYTES = 64;
  localparam int ADDR_W    = $clog2(IMG_BYTES);
  localparam int BPR_BASE  = 16;   // 16-bit bytes-per-row fields start here
  localparam int ROW_BASE  = 48;   // 8-bit row counts start here
  localparam int SLOTS     = 16;   // field slots present in the image
  localparam int LAST_ADDR = IMG_BYTES - 1;
endpackage

// File: rtl/tcfg_stage.sv
module tcfg_stage
  import tcfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  output logic                     commit,
  output logic [IMG_BYTES*8-1:0]   img
);
  logic [7:0] stage_q [IMG_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      commit <= 1'b0;
      for (int i = 0; i < IMG_BYTES; i++) stage_q[i] <= 8'h00;
    end else begin
      commit <= wr_en && (wr_addr == ADDR_W'(LAST_ADDR));
      if (wr_en) stage_q[wr_addr] <= wr_data;
    end
  end

  for (genvar i = 0; i < IMG_BYTES; i++) begin : g_flat
    assign img[8*i +: 8] = stage_q[i];
  end
endmodule

// File: rtl/tcfg_check.sv
module tcfg_check
  import tcfg_pkg::*;
#(
  parameter int NTILES   = 8,
  parameter int MAX_ROWS = 16,
  parameter int MAX_BPR  = 64,
  localparam int RW = $clog2(MAX_ROWS + 1),
  localparam int BW = $clog2(MAX_BPR + 1)
) (
  input  logic [IMG_BYTES*8-1:0] img,
  output logic                   zero_pal,
  output logic                   bad,
  output logic [7:0]             pal,
  output logic [NTILES*RW-1:0]   rows,
  output logic [NTILES*BW-1:0]   bpr
);
  logic [BPR_BASE-1:1] head_bad;
  logic [SLOTS-1:0]    slot_bad;

  assign pal = img[7:0];

  for (genvar i = 1; i < BPR_BASE; i++) begin : g_head
    assign head_bad[i] = img[8*i +: 8] != 8'h00;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [15:0] fld;
    logic [7:0]  cnt;
    assign fld = {img[8*(BPR_BASE+2*s+1) +: 8], img[8*(BPR_BASE+2*s) +: 8]};
    assign cnt = img[8*(ROW_BASE+s) +: 8];
    if (s < NTILES) begin : g_used
      assign slot_bad[s] = (int'(cnt) > MAX_ROWS) || (int'(fld) > MAX_BPR) ||
                           (fld[1:0] != 2'b00);
      assign rows[s*RW +: RW] = cnt[RW-1:0];
      assign bpr[s*BW +: BW]  = fld[BW-1:0];
    end else begin : g_rsvd
      assign slot_bad[s] = (fld != 16'h0000) || (cnt != 8'h00);
    end
  end

  assign zero_pal = (pal == 8'h00);
  assign bad      = (pal != 8'h01) || (|head_bad) || (|slot_bad);
endmodule

// File: rtl/tcfg_hold.sv
module tcfg_hold
  import tcfg_pkg::*;
#(
  parameter int NTILES = 8,
  parameter int RW     = 5,
  parameter int BW     = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic                   release_i,
  input  logic                   zero_pal,
  input  logic                   bad,
  input  logic [7:0]             pal,
  input  logic [NTILES*RW-1:0]   rows_in,
  input  logic [NTILES*BW-1:0]   bpr_in,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  output logic                   cfg_ok,
  output logic                   fault,
  output logic                   tile_clr,
  output logic [NTILES*RW-1:0]   tile_rows,
  output logic [NTILES*BW-1:0]   tile_bpr
);
  logic [7:0] pal_q;
  logic [7:0] rb;

  always_comb begin
    rb = 8'h00;
    if (cfg_ok) begin
      if (rd_addr == '0) rb = pal_q;
      for (int t = 0; t < NTILES; t++) begin
        if (rd_addr == ADDR_W'(BPR_BASE + 2*t)) rb = 8'(tile_bpr[t*BW +: BW]);
        if (rd_addr == ADDR_W'(ROW_BASE + t))   rb = 8'(tile_rows[t*RW +: RW]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ok    <= 1'b0;
      fault     <= 1'b0;
      tile_clr  <= 1'b0;
      pal_q     <= 8'h00;
      tile_rows <= '0;
      tile_bpr  <= '0;
      rd_data   <= 8'h00;
    end else begin
      fault    <= 1'b0;
      tile_clr <= 1'b0;
      if (release_i || (commit && zero_pal)) begin
        cfg_ok    <= 1'b0;
        pal_q     <= 8'h00;
        tile_rows <= '0;
        tile_bpr  <= '0;
        tile_clr  <= 1'b1;
      end else if (commit) begin
        if (bad) begin
          fault <= 1'b1;
        end else begin
          cfg_ok    <= 1'b1;
          pal_q     <= pal;
          tile_rows <= rows_in;
          tile_bpr  <= bpr_in;
        end
      end
      if (rd_en) rd_data <= rb;
    end
  end
endmodule

// File: rtl/tile_cfg_reg.sv
module tile_cfg_reg
  import tcfg_pkg::*;
#(
  parameter int NTILES   = 8,
  parameter int MAX_ROWS = 16,
  parameter int MAX_BPR  = 64,
  localparam int RW = $clog2(MAX_ROWS + 1),
  localparam int BW = $clog2(MAX_BPR + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  input  logic                  release_i,
  output logic                  cfg_ok,
  output logic                  fault,
  output logic                  tile_clr,
  output logic [NTILES*RW-1:0]  tile_rows,
  output logic [NTILES*BW-1:0]  tile_bpr
);
  logic                   commit, zero_pal, bad;
  logic [7:0]             pal;
  logic [IMG_BYTES*8-1:0] img;
  logic [NTILES*RW-1:0]   rows_s;
  logic [NTILES*BW-1:0]   bpr_s;

  tcfg_stage u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .img(img)
  );

  tcfg_check #(.NTILES(NTILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)) u_check (
    .img(img), .zero_pal(zero_pal), .bad(bad), .pal(pal),
    .rows(rows_s), .bpr(bpr_s)
  );

  tcfg_hold #(.NTILES(NTILES), .RW(RW), .BW(BW)) u_hold (
    .clk(clk), .rst(rst), .commit(commit), .release_i(release_i),
    .zero_pal(zero_pal), .bad(bad), .pal(pal), .rows_in(rows_s),
    .bpr_in(bpr_s), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_ok(cfg_ok), .fault(fault), .tile_clr(tile_clr),
    .tile_rows(tile_rows), .tile_bpr(tile_bpr)
  );
endmodule

// File: rtl/tcfg_checker.sv
module tcfg_checker #(
  parameter int NTILES   = 8,
  parameter int MAX_ROWS = 16,
  parameter int MAX_BPR  = 64,
  localparam int RW = $clog2(MAX_ROWS + 1),
  localparam int BW = $clog2(MAX_BPR + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 release_i,
  input logic                 rd_en,
  input logic [7:0]           rd_data,
  input logic                 cfg_ok,
  input logic                 fault,
  input logic                 tile_clr,
  input logic [NTILES*RW-1:0] tile_rows,
  input logic [NTILES*BW-1:0] tile_bpr
);
  assert_release_init_R10: assert property (@(posedge clk) disable iff (rst)
    release_i |=> (!cfg_ok && tile_clr));

  assert_release_no_fault_R11: assert property (@(posedge clk) disable iff (rst)
    release_i |=> !fault);

  assert_fault_keeps_cfg_R4: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(cfg_ok) && $stable(tile_rows) && $stable(tile_bpr)));

  assert_idle_shapes_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |-> (tile_rows == '0 && tile_bpr == '0));

  assert_unconf_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !cfg_ok) |=> (rd_data == 8'h00));

  for (genvar t = 0; t < NTILES; t++) begin : g_lim
    assert_shape_legal_R12: assert property (@(posedge clk) disable iff (rst)
      (int'(tile_rows[t*RW +: RW]) <= MAX_ROWS) &&
      (int'(tile_bpr[t*BW +: BW]) <= MAX_BPR) &&
      (tile_bpr[t*BW +: 2] == 2'b00));
  end
endmodule

bind tile_cfg_reg tcfg_checker #(.NTILES(NTILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)) u_chk (
  .clk(clk), .rst(rst), .release_i(release_i), .rd_en(rd_en), .rd_data(rd_data),
  .cfg_ok(cfg_ok), .fault(fault), .tile_clr(tile_clr),
  .tile_rows(tile_rows), .tile_bpr(tile_bpr)
);

// File: tb/sim_tile_cfg_reg.sv
`timescale 1ns/1ps
module sim_tile_cfg_reg;
  localparam int NT = 8, RW = 5, BW = 7;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, release_i = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic cfg_ok, fault, tile_clr;
  logic [NT*RW-1:0] tile_rows;
  logic [NT*BW-1:0] tile_bpr;

  int checks = 0, errors = 0;
  int m_rows [NT];
  int m_bpr  [NT];
  bit m_ok = 0;
  int s_rows [NT];
  int s_bpr  [NT];
  logic [7:0] s_pal;

  always #10 clk = ~clk;

  tile_cfg_reg u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] img_byte(int a);
    if (a == 0) return s_pal;
    if (a >= 16 && a < 16 + 2*NT) return ((a % 2) == 0) ? 8'(s_bpr[(a-16)/2]) : 8'(s_bpr[(a-16)/2] >> 8);
    if (a >= 48 && a < 48 + NT) return 8'(s_rows[a-48]);
    return 8'h00;
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // stage a full image; bad_a >= 0 overrides one byte; last byte (63) only if do_last
  task automatic stage_img(logic [7:0] pal, int rb, int rs, int bb, int bs,
                           int bad_a, logic [7:0] bad_v, bit do_last);
    s_pal = pal;
    for (int t = 0; t < NT; t++) begin s_rows[t] = rb + rs*t; s_bpr[t] = bb + bs*t; end
    for (int a = 0; a < 63; a++) wr(a, (a == bad_a) ? bad_v : img_byte(a));
    if (do_last) wr(63, (bad_a == 63) ? bad_v : img_byte(63));
  endtask

  task automatic adopt();
    m_ok = 1;
    for (int t = 0; t < NT; t++) begin m_rows[t] = s_rows[t]; m_bpr[t] = s_bpr[t]; end
  endtask

  task automatic clear_model();
    m_ok = 0;
    for (int t = 0; t < NT; t++) begin m_rows[t] = 0; m_bpr[t] = 0; end
  endtask

  task automatic check_state(string req, bit f_exp, bit c_exp);
    logic [NT*RW-1:0] er;
    logic [NT*BW-1:0] eb;
    for (int t = 0; t < NT; t++) begin er[t*RW +: RW] = RW'(m_rows[t]); eb[t*BW +: BW] = BW'(m_bpr[t]); end
    chk({req, " cfg_ok"}, 64'(cfg_ok), 64'(m_ok));
    chk({req, " rows"}, 64'(tile_rows), 64'(er));
    chk({req, " bpr"}, 64'(tile_bpr), 64'(eb));
    chk({req, " fault"}, 64'(fault), 64'(f_exp));
    chk({req, " tile_clr"}, 64'(tile_clr), 64'(c_exp));
  endtask

  task automatic rd(string req, int a, logic [7:0] exp);
    @(negedge clk); rd_en = 1; rd_addr = 6'(a);
    @(negedge clk); rd_en = 0;
    chk(req, 64'(rd_data), 64'(exp));
  endtask

  // after wr(63) returns, the commit edge is the next one
  task automatic after_commit(string req, bit f_exp, bit c_exp);
    @(negedge clk);
    check_state(req, f_exp, c_exp);
  endtask

  task automatic t_reset();
    clear_model();
    check_state("R1 reset", 0, 0);
    rd("R9 read unconfigured", 48, 8'h00);
  endtask

  task automatic t_valid();
    stage_img(8'h01, 1, 2, 8, 8, -1, 8'h00, 1);
    adopt();
    after_commit("R2 legal image", 0, 0);
    rd("R8 palette byte", 0, 8'h01);
    rd("R8 bpr low tile0", 16, 8'd8);
    rd("R8 bpr high tile0", 17, 8'h00);
    rd("R8 rows tile0", 48, 8'd1);
    rd("R8 rows tile7", 55, 8'd15);
    rd("R8 reserved rows", 56, 8'h00);
    rd("R8 reserved head", 5, 8'h00);
  endtask

  task automatic t_faults();
    stage_img(8'h02, 1, 1, 4, 4, -1, 8'h00, 1);
    after_commit("R4 bad palette", 1, 0);
    stage_img(8'h01, 17, 0, 4, 0, -1, 8'h00, 1);
    after_commit("R5 rows 17", 1, 0);
    stage_img(8'h01, 1, 0, 6, 0, -1, 8'h00, 1);
    after_commit("R6 bpr not mult of 4", 1, 0);
    stage_img(8'h01, 1, 0, 68, 0, -1, 8'h00, 1);
    after_commit("R6 bpr 68", 1, 0);
    stage_img(8'h01, 1, 0, 4, 0, 3, 8'h01, 1);
    after_commit("R7 reserved head byte", 1, 0);
    stage_img(8'h01, 1, 0, 4, 0, 40, 8'h04, 1);
    after_commit("R7 unused tile bpr", 1, 0);
    stage_img(8'h01, 1, 0, 4, 0, 63, 8'h01, 1);
    after_commit("R7 unused tile rows", 1, 0);
    rd("R4 readback kept", 48, 8'd1);
  endtask

  task automatic t_bounds();
    stage_img(8'h01, 16, -2, 64, -8, -1, 8'h00, 1);
    adopt();
    after_commit("R12 max rows and bpr", 0, 0);
    stage_img(8'h01, 0, 0, 0, 0, -1, 8'h00, 1);
    adopt();
    after_commit("R12 zero shapes", 0, 0);
  endtask

  task automatic t_partial();
    stage_img(8'h01, 3, 0, 12, 0, -1, 8'h00, 0);
    repeat (3) @(negedge clk);
    check_state("R13 no commit before byte 63", 0, 0);
    wr(63, 8'h00);
    adopt();
    after_commit("R13 commit on byte 63", 0, 0);
  endtask

  task automatic t_zero_pal();
    stage_img(8'h00, 20, 0, 7, 0, 3, 8'h55, 1);
    clear_model();
    after_commit("R3 palette zero init", 0, 1);
    @(negedge clk);
    check_state("R3 clear pulse one cycle", 0, 0);
    rd("R9 read after init", 0, 8'h00);
  endtask

  task automatic t_release();
    stage_img(8'h01, 2, 1, 16, 4, -1, 8'h00, 1);
    adopt();
    after_commit("R10 setup", 0, 0);
    @(negedge clk); release_i = 1;
    @(negedge clk); release_i = 0;
    clear_model();
    check_state("R10 release", 0, 1);
    @(negedge clk);
    check_state("R10 clear pulse one cycle", 0, 0);
    rd("R9 read after release", 16, 8'h00);
  endtask

  task automatic t_collide();
    stage_img(8'h01, 4, 0, 32, 0, -1, 8'h00, 0);
    @(negedge clk); wr_en = 1; wr_addr = 6'd63; wr_data = 8'h00;
    @(negedge clk); wr_en = 0; release_i = 1;
    @(negedge clk); release_i = 0;
    clear_model();
    check_state("R11 release beats commit", 0, 1);
    rd("R11 dropped image reads zero", 48, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_valid();
    t_faults();
    t_bounds();
    t_partial();
    t_zero_pal();
    t_release();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule